// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two W-bit operands over W clock cycles and retires one multiplier bit per cycle. A 2W-bit partial product is held in two W-bit halves, `hi` and `lo`. The multiplier is loaded into `lo` and is read from its least significant bit. In each step the multiplicand is added into `hi` when that bit is 1. The sum is then shifted right by one place as it is written back, so shifting costs no separate phase. The bit shifted out of `hi` enters the top of `lo`. As the multiplier bits leave `lo`, the low half of the product takes their place.

The `sgn` input selects two's-complement or unsigned operation for each run. In unsigned mode the carry-out of the addition becomes the new top bit of `hi`. In signed mode the sum is sign-extended by one bit and shifted arithmetically. The final step subtracts the multiplicand, so a negative multiplier needs no correction pass. A caller pulses `start` while the block is idle. `busy` is high during the run, and `done` is high for one cycle when the 2W-bit product is ready in `hi`:`lo`.

Top module: `seq_mul`

## Requirements
- R1: After reset, `busy`, `done`, `hi` and `lo` are all 0.
- R2: When `start` is high at a clock edge while `busy` is low, the block latches `mcand`, `mplier` and `sgn`, and `busy` is high from the next cycle.
- R3: After a start is accepted, `busy` stays high for exactly W cycles. `done` then goes high for exactly one cycle, in the same cycle that `busy` falls.
- R4: With `sgn` = 0, `{hi, lo}` at `done` equals the unsigned product of the two operands, all 2W bits of it. This includes operands whose partial sums carry out of the top bit.
- R5: With `sgn` = 1, `{hi, lo}` at `done` equals the 2W-bit two's-complement product. This includes a negative multiplier and the most negative value on either side.
- R6: While `busy` is high, `start`, `sgn`, `mcand` and `mplier` have no effect. The product reported at `done` is that of the operands latched at the start.
- R7: While the block is idle and `start` is low, `hi` and `lo` keep their values.
- R8: `done` and `busy` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a multiplication; taken only when idle |
| sgn | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| mcand | input | W | Multiplicand |
| mplier | input | W | Multiplier |
| busy | output | 1 | A multiplication is in progress |
| done | output | 1 | One-cycle pulse: the product is ready |
| hi | output | W | Upper half of the product |
| lo | output | W | Lower half of the product |

## Verification
A fault in the add/shift datapath shows up only at `done`, as a wrong `{hi, lo}`. A lost carry corrupts unsigned products with large operands. A wrong sign-fill or a missing final subtract corrupts signed products whose multiplier or multiplicand is negative. These faults are therefore exposed one run (W+1 cycles) after the start. A fault in the repetition counter or in the control state moves the `done` edge away from its fixed cycle, or lets a second start disturb a run in progress. Both can be observed at the first edge where the timing or the held result disagrees.

// File: rtl/seq_mul.sv
module seq_mul #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         sgn,
  input  logic [W-1:0] mcand,
  input  logic [W-1:0] mplier,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  x_q;
  logic          sgn_q;
  logic [CW-1:0] cnt_q;

  logic          last;
  logic [W:0]    hi_ext, x_ext, addend, sum;

  assign last   = (cnt_q == CW'(1));
  assign hi_ext = sgn_q ? {hi[W-1], hi} : {1'b0, hi};
  assign x_ext  = sgn_q ? {x_q[W-1], x_q} : {1'b0, x_q};
  assign addend = !lo[0] ? '0 : ((sgn_q && last) ? (~x_ext + 1'b1) : x_ext);
  assign sum    = hi_ext + addend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      hi    <= '0;
      lo    <= '0;
      x_q   <= '0;
      sgn_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy  <= 1'b1;
          hi    <= '0;
          lo    <= mplier;
          x_q   <= mcand;
          sgn_q <= sgn;
          cnt_q <= CW'(W);
        end
      end else begin
        hi    <= sum[W:1];
        lo    <= {sum[0], lo[W-1:1]};
        cnt_q <= cnt_q - 1'b1;
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/seq_mul_chk.sv
module seq_mul_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] hi,
  input logic [W-1:0] lo
);
  localparam int RW = $clog2(W + 2);
  logic [RW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             run_q <= '0;
    else if (start && !busy) run_q <= '0;
    else if (busy)           run_q <= run_q + 1'b1;
  end

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3
  run_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done && run_q == RW'(W)));

  // R6
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(hi) && $stable(lo)));

  // R8
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
endmodule

bind seq_mul seq_mul_chk #(.W(W)) chk_i (.*);

// File: tb/seq_mul_tb_top.sv
module seq_mul_tb_top;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         sgn = 1'b0;
  logic [W-1:0] mcand = '0;
  logic [W-1:0] mplier = '0;
  logic         busy, done;
  logic [W-1:0] hi, lo;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  seq_mul #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .sgn(sgn),
    .mcand(mcand), .mplier(mplier),
    .busy(busy), .done(done), .hi(hi), .lo(lo)
  );

  function automatic logic [2*W-1:0] ref_prod(logic [W-1:0] a, logic [W-1:0] b, logic s);
    logic [2*W-1:0] ea, eb;
    ea = s ? {{W{a[W-1]}}, a} : {{W{1'b0}}, a};
    eb = s ? {{W{b[W-1]}}, b} : {{W{1'b0}}, b};
    return ea * eb;
  endfunction

  task automatic check(string req, logic [2*W-1:0] act, logic [2*W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(logic [W-1:0] a, logic [W-1:0] b, logic s, bit disturb);
    logic [2*W-1:0] exp;
    int n;
    exp = ref_prod(a, b, s);
    @(negedge clk);
    mcand = a; mplier = b; sgn = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2 busy after start", {63'd0, busy}, 64'd1);
    n = 1;
    if (disturb) begin
      mcand = ~a; mplier = b ^ 32'h5A5A_1234; sgn = ~s; start = 1'b1;
    end
    while (!done && n < 4 * W) begin
      check("R8 busy/done exclusive", {63'd0, busy && done}, 64'd0);
      @(negedge clk);
      n++;
      if (disturb && n == 5) start = 1'b0;
    end
    start = 1'b0;
    check("R3 done cycle", 64'(n), 64'(W + 1));
    check("R3 busy low at done", {63'd0, busy}, 64'd0);
    if (disturb) check("R6 inputs ignored while busy", {hi, lo}, exp);
    else if (s)  check("R5 signed product", {hi, lo}, exp);
    else         check("R4 unsigned product", {hi, lo}, exp);
    @(negedge clk);
    check("R3 done one cycle", {63'd0, done}, 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [2*W-1:0] held;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {hi, lo}, 64'd0);
    check("R1 reset flags", {62'd0, busy, done}, 64'd0);
    rst_n = 1'b1;

    run(32'd0, 32'hFFFF_FFFF, 1'b0, 0);
    run(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 0);
    run(32'h8000_0001, 32'hC000_0003, 1'b0, 0);
    run(32'h8000_0000, 32'h8000_0000, 1'b1, 0);
    run(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 0);
    run(32'h8000_0000, 32'd1, 1'b1, 0);
    run(32'd7, 32'hFFFF_FFF9, 1'b1, 0);
    run(32'hFFFF_FFF9, 32'd7, 1'b1, 0);
    run(32'h7FFF_FFFF, 32'h8000_0000, 1'b1, 0);
    run(32'h1234_5678, 32'h9ABC_DEF0, 1'b0, 1);
    run(32'hF234_5678, 32'h9ABC_DEF0, 1'b1, 1);

    held = {hi, lo};
    repeat (6) @(negedge clk);
    mcand = 32'hDEAD_BEEF; mplier = 32'h0BAD_F00D;
    repeat (3) @(negedge clk);
    check("R7 result held while idle", {hi, lo}, held);

    for (int i = 0; i < 200; i++) begin
      run($urandom, $urandom, 1'($urandom), 0);
    end

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule